// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block sits on a 32-bit host register bus and gives indirect access to two downstream spaces through a pointer register and a four-byte data window. The host first loads the pointer. Bit 31 of the pointer chooses the space and the lower bits give the address. Reads and writes to the window are then sent downstream to the chosen space. The byte offset inside the window is added to the pointer, and the access size (1, 2 or 4 bytes) is kept.

With bit 31 set, the target is the linear video memory port. This is a byte-addressed, little-endian path with a bounds check that depends on the access size. A request that would run past the end of memory is dropped without any downstream activity. With bit 31 clear, the target is the device register port. Register accesses use byte lanes, so a sub-word access touches only its own lanes of the addressed 32-bit word. Host accesses that hit neither the pointer nor the window go straight to the register port with the same lane rules. A pointer that steers the window back onto the pointer or the window itself is treated as a dead target, so redirection never recurses.

Every host access finishes with a single-cycle ready pulse. Host data is right-justified on both the write and the read paths.

Top module: `idxwin_top`

## Requirements
- R1: After reset, host_ready_o, reg_req_o and mem_req_o are low, and a read of the pointer returns 0.
- R2: The pointer lives at host address IDX_ADDR. A 4-byte write stores all 32 bits and a read returns the stored value. A sub-word access at byte offset o and size s reads or replaces only bits [8(o+s)-1:8o].
- R3: With pointer bit 31 set, a window access at offset b (host address DATA_ADDR+b) issues one memory request at byte address pointer[30:0]+b with the same size code. Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes. Data is little-endian and right-justified: byte 0 is bits [7:0].
- R4: A memory access is issued only when address + size in bytes <= MEM_BYTES. Otherwise there is no memory request, a read returns 0, and a write leaves memory unchanged.
- R5: With pointer bit 31 clear, a window access goes to register address t = pointer + b. reg_addr_o is t with bits [1:0] cleared. reg_be_o has bits t[1:0] to t[1:0]+s-1 set. Write data is shifted into those lanes. Read data is taken from those lanes, right-justified and zero-extended.
- R6: When the register port answers with reg_ok_i low (unmapped address), the host read returns 0 whatever reg_rdata_i carries.
- R7: A register target whose word equals the pointer word or the window word is dropped. There is no downstream request, a read returns 0, and the pointer is left unchanged.
- R8: Register-space targets are dropped (no request, read 0) in three cases: the access crosses a 32-bit word boundary, t has bits set at or above HOST_AW, or the size code is 3.
- R9: Host accesses outside the pointer and window words go to the register port at the host address, with the lane rules of R5.
- R10: host_ready_o is a one-cycle pulse. It rises one cycle after the request for pointer or dropped accesses. For forwarded accesses it rises one cycle after the downstream acknowledge. A downstream request and its address stay stable until acknowledged.
- R11: reg_req_o and mem_req_o are never high together, and each host access makes at most one downstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host request, held until host_ready_o |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | HOST_AW | Host byte address |
| host_size_i | input | 2 | Size code: 0=1, 1=2, 2=4 bytes |
| host_wdata_i | input | 32 | Host write data, right-justified |
| host_rdata_o | output | 32 | Host read data, right-justified |
| host_ready_o | output | 1 | One-cycle completion pulse |
| reg_req_o | output | 1 | Register port request |
| reg_we_o | output | 1 | Register port write enable |
| reg_addr_o | output | HOST_AW | Word-aligned register address |
| reg_be_o | output | 4 | Register byte enables |
| reg_wdata_o | output | 32 | Lane-aligned register write data |
| reg_rdata_i | input | 32 | Register read word |
| reg_ok_i | input | 1 | Register address mapped, valid with ack |
| reg_ack_i | input | 1 | Register port acknowledge |
| mem_req_o | output | 1 | Memory port request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_size_o | output | 2 | Memory size code |
| mem_wdata_o | output | 32 | Memory write data, little-endian, right-justified |
| mem_rdata_i | input | 32 | Memory read data, little-endian, right-justified |
| mem_ack_i | input | 1 | Memory port acknowledge |

## Verification
Pointer accesses and dropped accesses answer on the first clock edge after the request is taken, so ready is seen one edge later. A forwarded access raises the downstream request on that first edge. The bench models answer one edge after that, and ready follows on the next edge, three edges after the request in total. The host task drives at falling edges and counts the edges until ready. It checks that count, samples read data at the falling edge where ready is seen, and checks downstream side effects only after the access has completed. Dropped cases are also confirmed by unchanged request counters in the downstream models.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
  typedef enum logic [1:0] {RT_LOCAL, RT_REG, RT_MEM, RT_DROP} route_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} state_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      2'd2:    size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00ff;
      2'd1:    size_mask = 32'h0000_ffff;
      2'd2:    size_mask = 32'hffff_ffff;
      default: size_mask = 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/idxwin_route.sv
module idxwin_route
  import idxwin_pkg::*;
#(
  parameter int                  HOST_AW   = 14,
  parameter logic [HOST_AW-1:0]  IDX_ADDR  = '0,
  parameter logic [HOST_AW-1:0]  DATA_ADDR = HOST_AW'(4),
  parameter logic [31:0]         MEM_BYTES = 32'h0100_0000
) (
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [1:0]         size_i,
  input  logic [31:0]        index_i,
  output route_e             route_o,
  output logic [31:0]        tgt_o
);
  logic [2:0]  nb;
  logic [1:0]  off;
  logic        is_idx, is_dat;
  logic [32:0] mem_a, mem_end, reg_t;
  logic        reg_hi_ok, reg_self;

  function automatic logic fits(input logic [1:0] o, input logic [2:0] n);
    fits = ({1'b0, o} + n) <= 3'd4;
  endfunction

  assign nb      = size_bytes(size_i);
  assign off     = host_addr_i[1:0];
  assign is_idx  = host_addr_i[HOST_AW-1:2] == IDX_ADDR[HOST_AW-1:2];
  assign is_dat  = host_addr_i[HOST_AW-1:2] == DATA_ADDR[HOST_AW-1:2];
  assign mem_a   = {2'b00, index_i[30:0]} + 33'(off);
  assign mem_end = mem_a + 33'(nb);
  assign reg_t   = {1'b0, index_i} + 33'(off);
  assign reg_hi_ok = reg_t[32:HOST_AW] == '0;
  assign reg_self  = (reg_t[HOST_AW-1:2] == IDX_ADDR[HOST_AW-1:2]) ||
                     (reg_t[HOST_AW-1:2] == DATA_ADDR[HOST_AW-1:2]);

  always_comb begin
    route_o = RT_DROP;
    tgt_o   = 32'(host_addr_i);
    if (nb == 3'd0) begin
      route_o = RT_DROP;
    end else if (is_idx) begin
      route_o = fits(off, nb) ? RT_LOCAL : RT_DROP;
    end else if (is_dat) begin
      if (index_i[31]) begin
        tgt_o   = mem_a[31:0];
        route_o = (mem_end <= {1'b0, MEM_BYTES}) ? RT_MEM : RT_DROP;
      end else begin
        tgt_o   = reg_t[31:0];
        route_o = (reg_hi_ok && !reg_self && fits(reg_t[1:0], nb)) ? RT_REG : RT_DROP;
      end
    end else begin
      route_o = fits(off, nb) ? RT_REG : RT_DROP;
    end
  end
endmodule

// File: rtl/idxwin_lane_wr.sv
module idxwin_lane_wr
  import idxwin_pkg::*;
(
  input  logic [1:0]  off_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] data_i,
  output logic [3:0]  be_o,
  output logic [31:0] data_o
);
  logic [2:0] lo, hi;
  assign lo = {1'b0, off_i};
  assign hi = lo + size_bytes(size_i);

  for (genvar k = 0; k < 4; k++) begin : g_be
    assign be_o[k] = (3'(k) >= lo) && (3'(k) < hi);
  end

  assign data_o = (data_i & size_mask(size_i)) << {off_i, 3'b000};
endmodule

// File: rtl/idxwin_lane_rd.sv
module idxwin_lane_rd
  import idxwin_pkg::*;
(
  input  logic [31:0] word_i,
  input  logic [1:0]  off_i,
  input  logic [1:0]  size_i,
  output logic [31:0] data_o
);
  assign data_o = (word_i >> {off_i, 3'b000}) & size_mask(size_i);
endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
  import idxwin_pkg::*;
#(
  parameter int                  HOST_AW   = 14,
  parameter logic [HOST_AW-1:0]  IDX_ADDR  = '0,
  parameter logic [HOST_AW-1:0]  DATA_ADDR = HOST_AW'(4),
  parameter logic [31:0]         MEM_BYTES = 32'h0100_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [1:0]         host_size_i,
  input  logic [31:0]        host_wdata_i,
  output logic [31:0]        host_rdata_o,
  output logic               host_ready_o,
  output logic               reg_req_o,
  output logic               reg_we_o,
  output logic [HOST_AW-1:0] reg_addr_o,
  output logic [3:0]         reg_be_o,
  output logic [31:0]        reg_wdata_o,
  input  logic [31:0]        reg_rdata_i,
  input  logic               reg_ok_i,
  input  logic               reg_ack_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [31:0]        mem_addr_o,
  output logic [1:0]         mem_size_o,
  output logic [31:0]        mem_wdata_o,
  input  logic [31:0]        mem_rdata_i,
  input  logic               mem_ack_i
);
  state_e      st_q;
  route_e      route_d, route_q;
  logic [31:0] index_q, index_new;
  logic [31:0] tgt_d, tgt_q;
  logic [1:0]  size_q;
  logic        we_q;
  logic [3:0]  be_d, be_q;
  logic [31:0] lane_d, lane_q, wmem_q, rdata_q;
  logic [31:0] loc_rd, dn_word, dn_rd;
  logic [1:0]  dn_off;
  logic        dn_ack;

  idxwin_route #(
    .HOST_AW(HOST_AW), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR), .MEM_BYTES(MEM_BYTES)
  ) u_route (
    .host_addr_i(host_addr_i), .size_i(host_size_i), .index_i(index_q),
    .route_o(route_d), .tgt_o(tgt_d)
  );

  idxwin_lane_wr u_wr (
    .off_i(tgt_d[1:0]), .size_i(host_size_i), .data_i(host_wdata_i),
    .be_o(be_d), .data_o(lane_d)
  );

  idxwin_lane_rd u_rd_loc (
    .word_i(index_q), .off_i(tgt_d[1:0]), .size_i(host_size_i), .data_o(loc_rd)
  );

  // memory data is already right-justified, register data sits in its lanes
  assign dn_word = (route_q == RT_MEM) ? mem_rdata_i : (reg_ok_i ? reg_rdata_i : 32'h0);
  assign dn_off  = (route_q == RT_MEM) ? 2'b00 : tgt_q[1:0];
  assign dn_ack  = (route_q == RT_MEM) ? mem_ack_i : reg_ack_i;

  idxwin_lane_rd u_rd_dn (
    .word_i(dn_word), .off_i(dn_off), .size_i(size_q), .data_o(dn_rd)
  );

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      index_new[8*k +: 8] = be_d[k] ? lane_d[8*k +: 8] : index_q[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      route_q <= RT_DROP;
      index_q <= '0;
      tgt_q   <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      lane_q  <= '0;
      wmem_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (host_req_i) begin
          route_q <= route_d;
          tgt_q   <= tgt_d;
          size_q  <= host_size_i;
          we_q    <= host_we_i;
          be_q    <= be_d;
          lane_q  <= lane_d;
          wmem_q  <= host_wdata_i & size_mask(host_size_i);
          rdata_q <= '0;
          case (route_d)
            RT_LOCAL: begin
              if (host_we_i) index_q <= index_new;
              else           rdata_q <= loc_rd;
              st_q <= ST_DONE;
            end
            RT_DROP: st_q <= ST_DONE;
            default: st_q <= ST_WAIT;
          endcase
        end
        ST_WAIT: if (dn_ack) begin
          if (!we_q) rdata_q <= dn_rd;
          st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign host_ready_o = st_q == ST_DONE;
  assign host_rdata_o = rdata_q;
  assign reg_req_o    = (st_q == ST_WAIT) && (route_q == RT_REG);
  assign reg_we_o     = we_q;
  assign reg_addr_o   = {tgt_q[HOST_AW-1:2], 2'b00};
  assign reg_be_o     = be_q;
  assign reg_wdata_o  = lane_q;
  assign mem_req_o    = (st_q == ST_WAIT) && (route_q == RT_MEM);
  assign mem_we_o     = we_q;
  assign mem_addr_o   = tgt_q;
  assign mem_size_o   = size_q;
  assign mem_wdata_o  = wmem_q;

  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_o && mem_req_o));
  assert_mem_bounds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (33'(mem_addr_o) + 33'(size_bytes(mem_size_o))) <= {1'b0, MEM_BYTES});
  assert_reg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o));
  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  assert_ready_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |=> !host_ready_o);
  assert_one_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_ack_i || mem_ack_i) && (reg_req_o || mem_req_o) |=> !reg_req_o && !mem_req_o);
  assert_be_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> $countones(reg_be_o) inside {1, 2, 4});
  assert_no_self_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> reg_addr_o[HOST_AW-1:2] != IDX_ADDR[HOST_AW-1:2] &&
                  reg_addr_o[HOST_AW-1:2] != DATA_ADDR[HOST_AW-1:2]);
endmodule

// File: tb/tb_idxwin_top.sv
`timescale 1ns/1ps
module tb_idxwin_top;
  localparam int AW = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_req_i = 1'b0, host_we_i = 1'b0;
  logic [AW-1:0] host_addr_i = '0;
  logic [1:0]    host_size_i = '0;
  logic [31:0]   host_wdata_i = '0;
  logic [31:0]   host_rdata_o;
  logic          host_ready_o;
  logic          reg_req_o, reg_we_o;
  logic [AW-1:0] reg_addr_o;
  logic [3:0]    reg_be_o;
  logic [31:0]   reg_wdata_o;
  logic [31:0]   reg_rdata_i = '0;
  logic          reg_ok_i = 1'b0, reg_ack_i = 1'b0;
  logic          mem_req_o, mem_we_o;
  logic [31:0]   mem_addr_o;
  logic [1:0]    mem_size_o;
  logic [31:0]   mem_wdata_o;
  logic [31:0]   mem_rdata_i = '0;
  logic          mem_ack_i = 1'b0;

  int n_chk = 0, n_err = 0, n_reg = 0, n_mem = 0, n_both = 0;
  logic [31:0] regs [16];
  logic [7:0]  mem  [64];
  logic [3:0]  last_be = '0;
  logic [31:0] mrd;

  always #2 clk_i = ~clk_i;

  idxwin_top #(.HOST_AW(AW), .MEM_BYTES(32'd64)) dut (.*);

  // register space model: 0x100..0x13f mapped, one-cycle ack
  always @(posedge clk_i) begin
    reg_ack_i <= 1'b0;
    if (reg_req_o && !reg_ack_i) begin
      reg_ack_i <= 1'b1;
      n_reg++;
      last_be <= reg_be_o;
      if (reg_addr_o[13:6] == 8'h04) begin
        reg_ok_i    <= 1'b1;
        reg_rdata_i <= regs[reg_addr_o[5:2]];
        if (reg_we_o)
          for (int k = 0; k < 4; k++)
            if (reg_be_o[k]) regs[reg_addr_o[5:2]][8*k +: 8] <= reg_wdata_o[8*k +: 8];
      end else begin
        reg_ok_i    <= 1'b0;
        reg_rdata_i <= 32'hdead_beef;
      end
    end
  end

  // byte memory model, little-endian, one-cycle ack
  always @(posedge clk_i) begin
    mem_ack_i <= 1'b0;
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i <= 1'b1;
      n_mem++;
      mrd = '0;
      for (int k = 0; k < 4; k++) begin
        if (k < (mem_size_o == 2'd0 ? 1 : mem_size_o == 2'd1 ? 2 : 4)) begin
          if (mem_we_o) mem[6'(mem_addr_o + 32'(k))] <= mem_wdata_o[8*k +: 8];
          mrd[8*k +: 8] = mem[6'(mem_addr_o + 32'(k))];
        end
      end
      mem_rdata_i <= mrd;
    end
  end

  always @(posedge clk_i) if (reg_req_o && mem_req_o) n_both++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [AW-1:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = we; host_addr_i = a; host_size_i = sz; host_wdata_i = wd;
    lat = 0;
    do begin @(negedge clk_i); lat++; end while (!host_ready_o && lat < 50);
    rd = host_rdata_o;
    host_req_i = 1'b0; host_we_i = 1'b0;
  endtask

  task automatic set_idx(input logic [31:0] v);
    logic [31:0] rd; int lat;
    xfer(1'b1, '0, 2'd2, v, rd, lat);
  endtask

  task automatic t_reset;
    logic [31:0] rd; int lat;
    check("R1 ready", 32'(host_ready_o), 0);
    check("R1 reqs", {reg_req_o, mem_req_o}, 0);
    xfer(1'b0, '0, 2'd2, 0, rd, lat);
    check("R1 index", rd, 0);
  endtask

  task automatic t_index;
    logic [31:0] rd; int lat;
    set_idx(32'h8000_0010);
    xfer(1'b0, '0, 2'd2, 0, rd, lat);
    check("R2 full", rd, 32'h8000_0010);
    check("R10 local latency", lat, 1);
    @(negedge clk_i);
    check("R10 pulse", 32'(host_ready_o), 0);
    xfer(1'b1, 14'h1, 2'd0, 32'hffff_ffab, rd, lat);
    xfer(1'b0, '0, 2'd2, 0, rd, lat);
    check("R2 byte write", rd, 32'h8000_ab10);
    xfer(1'b0, 14'h2, 2'd1, 0, rd, lat);
    check("R2 half read", rd, 32'h8000);
  endtask

  task automatic t_mem;
    logic [31:0] rd; int lat;
    set_idx(32'h8000_0008);
    xfer(1'b1, 14'h4, 2'd2, 32'h4433_2211, rd, lat);
    check("R3 le write", {mem[11], mem[10], mem[9], mem[8]}, 32'h4433_2211);
    check("R10 fwd latency", lat, 3);
    xfer(1'b0, 14'h5, 2'd1, 0, rd, lat);
    check("R3 offset read", rd, 32'h3322);
    xfer(1'b1, 14'h7, 2'd0, 32'h99, rd, lat);
    check("R3 byte write", {mem[11], mem[10]}, 16'h9933);
  endtask

  task automatic t_bounds;
    logic [31:0] rd; int lat, n0;
    @(negedge clk_i); mem[62] = 8'ha1; mem[63] = 8'hb2;
    set_idx(32'h8000_003e);
    xfer(1'b0, 14'h4, 2'd1, 0, rd, lat);
    check("R4 last half", rd, 32'hb2a1);
    n0 = n_mem;
    xfer(1'b0, 14'h5, 2'd1, 0, rd, lat);
    check("R4 over read", rd, 0);
    check("R4 no req", n_mem, n0);
    check("R10 drop latency", lat, 1);
    xfer(1'b1, 14'h5, 2'd1, 32'hffff, rd, lat);
    check("R4 write dropped", 32'(mem[63]), 32'hb2);
    xfer(1'b0, 14'h5, 2'd0, 0, rd, lat);
    check("R4 last byte", rd, 32'hb2);
    set_idx(32'h8000_0040);
    xfer(1'b0, 14'h4, 2'd0, 0, rd, lat);
    check("R4 past end", n_mem, n0 + 1);
  endtask

  task automatic t_reg;
    logic [31:0] rd; int lat;
    set_idx(32'h0000_0104);
    xfer(1'b1, 14'h4, 2'd2, 32'h1234_5678, rd, lat);
    check("R5 word write", regs[1], 32'h1234_5678);
    xfer(1'b1, 14'h6, 2'd0, 32'hcd, rd, lat);
    check("R5 lane write", regs[1], 32'h12cd_5678);
    check("R5 be", 32'(last_be), 32'h4);
    xfer(1'b0, 14'h6, 2'd1, 0, rd, lat);
    check("R5 half read", rd, 32'h12cd);
  endtask

  task automatic t_direct;
    logic [31:0] rd; int lat, n0;
    xfer(1'b1, 14'h108, 2'd2, 32'hcafe_f00d, rd, lat);
    check("R9 direct write", regs[2], 32'hcafe_f00d);
    xfer(1'b0, 14'h10b, 2'd0, 0, rd, lat);
    check("R9 direct byte", rd, 32'hca);
    n0 = n_reg;
    xfer(1'b0, 14'h10a, 2'd2, 0, rd, lat);
    check("R8 direct cross", rd, 0);
    set_idx(32'h0000_0106);
    xfer(1'b0, 14'h4, 2'd2, 0, rd, lat);
    check("R8 window cross", n_reg, n0);
    xfer(1'b0, 14'h6, 2'd2, 0, rd, lat);
    check("R5 window to 0x108", rd, 32'hcafe_f00d);
  endtask

  task automatic t_unmapped;
    logic [31:0] rd; int lat, n0;
    set_idx(32'h0000_0200);
    n0 = n_reg;
    xfer(1'b0, 14'h4, 2'd2, 0, rd, lat);
    check("R6 unmapped read", rd, 0);
    check("R6 forwarded", n_reg, n0 + 1);
  endtask

  task automatic t_self;
    logic [31:0] rd; int lat, n0;
    set_idx(32'h0000_0001);
    n0 = n_reg;
    xfer(1'b1, 14'h4, 2'd0, 32'hff, rd, lat);
    xfer(1'b0, '0, 2'd2, 0, rd, lat);
    check("R7 index kept", rd, 32'h1);
    set_idx(32'h0000_0004);
    xfer(1'b0, 14'h4, 2'd2, 0, rd, lat);
    check("R7 window self read", rd, 0);
    check("R7 no req", n_reg, n0);
  endtask

  task automatic t_high;
    logic [31:0] rd; int lat, n0;
    n0 = n_reg;
    set_idx(32'h0001_0104);
    xfer(1'b0, 14'h4, 2'd2, 0, rd, lat);
    check("R8 high bits", rd, 0);
    set_idx(32'h0000_0104);
    xfer(1'b0, 14'h4, 2'd3, 0, rd, lat);
    check("R8 bad size", rd, 0);
    check("R8 no req", n_reg, n0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_index;
    t_mem;
    t_bounds;
    t_reg;
    t_direct;
    t_unmapped;
    t_self;
    t_high;
    check("R11 exclusive", n_both, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule